// File: doc/BRIEF.md
# Eight-Bit Timer with Two Compare Channels

An 8-bit up-counter for a microcontroller-style peripheral. A 3-bit clock-select field sets the counting rate. The counter can be stopped, stepped from one of several taps of a shared free-running prescaler, or stepped by edges on an external count pin. The external pin is synchronised into the system clock domain and edge-detected. Edges on that pin advance the counter whatever drives the pin, so software that toggles a pin wired back to the counter can step the count itself.

Two compare registers are checked against the counter on every timer tick. A hit on a tick produces a one-cycle match strobe and sets that channel's flag. A wrap from 255 to 0 sets an overflow flag. Each flag raises an interrupt request only when its mask bit and the global enable input are both high. A bus write to the counter suppresses compare hits on the tick that follows it. This stops a freshly loaded value from matching at once.

The counter, both compare values, clock select, mask and flags are reached over a simple register bus. Writes are synchronous and reads are combinational.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: After reset the counter, both compare registers, clock select, mask and flags read as zero, and all interrupt requests and match strobes are low.
- R2: The register map is as follows. Address 0 is the counter, 1 is compare A and 2 is compare B; these three are 8-bit read/write. Address 3 is clock select in bits 2:0, address 4 is the mask in bits 2:0, and address 5 is the flags in bits 2:0. Unused bits and unused addresses read zero. A write takes effect at the clock edge that samples it.
- R3: A bus write to the counter blocks any compare match on the first timer tick after the write. Overflow detection on that tick is not blocked. A counter write in the same cycle as a tick wins, and the tick is lost.
- R4: On a timer tick, a channel whose compare value equals the current counter value pulses its match strobe for that cycle. At the next edge it sets its flag (compare A at flag bit 0, compare B at bit 2). Without a tick no match occurs, even while the counter holds a matching value.
- R5: The clock select codes are 000 stop, 001 every clock, 010 every 8, 011 every 64, 100 every 256 and 101 every 1024 system clocks. The divided codes tick when the low bits of a shared prescaler, free-running since reset, are all ones.
- R6: Code 110 ticks once per falling edge and code 111 once per rising edge of the external count pin. The pin is sampled through a two-flop synchroniser, and each edge produces exactly one tick.
- R7: A tick at counter value 255 wraps the counter to 0 and sets the overflow flag at bit 1.
- R8: Writing a one to a flag bit at address 5 clears it, and writing zero leaves it unchanged. A flag set and a clear landing in the same cycle leave the flag set.
- R9: An interrupt request (compare A, overflow, compare B) is high exactly when its flag, its mask bit (mask bits 0, 1, 2 respectively) and the global enable input are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cnt_pin | input | 1 | External count pin, asynchronous |
| glb_ie | input | 1 | Global interrupt enable |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |
| match_a | output | 1 | Compare A match strobe |
| match_b | output | 1 | Compare B match strobe |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a flag being set by a match or wrap and software clearing that flag. The second pair is a bus write to the counter and a timer tick. Random bus traffic at the every-clock rate produces both pairs often. Directed sequences also place a write-one-to-clear on the exact cycle of a match, and a counter reload just before a tick that would have matched. A cycle-level model in the bench judges the results: set must win over clear, the counter write must win over the tick, and the following tick must carry no match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } csel_e;

  localparam logic [2:0] ADDR_CNT  = 3'd0;
  localparam logic [2:0] ADDR_CMPA = 3'd1;
  localparam logic [2:0] ADDR_CMPB = 3'd2;
  localparam logic [2:0] ADDR_CSEL = 3'd3;
  localparam logic [2:0] ADDR_MASK = 3'd4;
  localparam logic [2:0] ADDR_FLAG = 3'd5;

  localparam int NFLAG  = 3;
  localparam int FB_CMPA = 0;
  localparam int FB_OVF  = 1;
  localparam int FB_CMPB = 2;

  // number of all-ones low prescaler bits needed for a tick
  function automatic int tap_bits(input logic [2:0] code);
    case (code)
      CS_DIV8:    return 3;
      CS_DIV64:   return 6;
      CS_DIV256:  return 8;
      CS_DIV1024: return 10;
      default:    return 0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] csel,
  input  logic       ext_rise,
  input  logic       ext_fall,
  output logic       tick
);
  import tmr_pkg::*;

  logic [PW-1:0] pre_q;

  function automatic logic [PW-1:0] low_mask(input logic [2:0] code);
    logic [31:0] m;
    m = (32'd1 << tap_bits(code)) - 32'd1;
    return m[PW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    case (csel_e'(csel))
      CS_STOP:     tick = 1'b0;
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default:     tick = &(pre_q | ~low_mask(csel));
    endcase
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], pin};
  end

  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W   = 8,
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  cnt_we,
  input  logic [W-1:0]          cnt_wdata,
  input  logic [NCH-1:0][W-1:0] cmp,
  output logic [W-1:0]          cnt,
  output logic                  blk,
  output logic [NCH-1:0]        match,
  output logic                  wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic hit(input logic t, input logic b,
                               input logic [W-1:0] c, input logic [W-1:0] r);
    return t && !b && (c == r);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (cnt_we) begin
      cnt <= cnt_wdata;
      blk <= 1'b1;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      blk <= 1'b0;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign match[i] = hit(tick, blk, cnt, cmp[i]);
  end

  assign wrap = tick && (cnt == TOP);
endmodule

// File: rtl/tmr8_dual_cmp.sv
module tmr8_dual_cmp #(
  parameter int W  = 8,
  parameter int PW = 10,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          cnt_pin,
  input  logic          glb_ie,
  output logic          irq_cmpa,
  output logic          irq_ovf,
  output logic          irq_cmpb,
  output logic          match_a,
  output logic          match_b
);
  import tmr_pkg::*;

  localparam int NCH = 2;

  logic [NCH-1:0][W-1:0] cmp_q;
  logic [2:0]            csel_q;
  logic [NFLAG-1:0]      mask_q, flag_q, flag_set, flag_clr;
  logic [W-1:0]          cnt_q;
  logic [NCH-1:0]        match;
  logic                  tick, blk, wrap, cnt_we, ext_rise, ext_fall;

  function automatic logic wr_at(input logic we, input logic [AW-1:0] a,
                                 input logic [2:0] target);
    return we && (a == AW'(target));
  endfunction

  assign cnt_we = wr_at(bus_we, bus_addr, ADDR_CNT);

  tmr_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .rise(ext_rise), .fall(ext_fall)
  );

  tmr_prescale #(.PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .csel(csel_q),
    .ext_rise(ext_rise), .ext_fall(ext_fall), .tick(tick)
  );

  tmr_core #(.W(W), .NCH(NCH)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we),
    .cnt_wdata(bus_wdata), .cmp(cmp_q), .cnt(cnt_q), .blk(blk),
    .match(match), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      csel_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_at(bus_we, bus_addr, ADDR_CMPA)) cmp_q[0] <= bus_wdata;
      if (wr_at(bus_we, bus_addr, ADDR_CMPB)) cmp_q[1] <= bus_wdata;
      if (wr_at(bus_we, bus_addr, ADDR_CSEL)) csel_q  <= bus_wdata[2:0];
      if (wr_at(bus_we, bus_addr, ADDR_MASK)) mask_q  <= bus_wdata[NFLAG-1:0];
    end
  end

  always_comb begin
    flag_set          = '0;
    flag_set[FB_CMPA] = match[0];
    flag_set[FB_OVF]  = wrap;
    flag_set[FB_CMPB] = match[1];
    flag_clr = wr_at(bus_we, bus_addr, ADDR_FLAG) ? bus_wdata[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  always_comb begin
    case (bus_addr)
      AW'(ADDR_CNT):  bus_rdata = cnt_q;
      AW'(ADDR_CMPA): bus_rdata = cmp_q[0];
      AW'(ADDR_CMPB): bus_rdata = cmp_q[1];
      AW'(ADDR_CSEL): bus_rdata = {{(W-3){1'b0}}, csel_q};
      AW'(ADDR_MASK): bus_rdata = {{(W-NFLAG){1'b0}}, mask_q};
      AW'(ADDR_FLAG): bus_rdata = {{(W-NFLAG){1'b0}}, flag_q};
      default:        bus_rdata = '0;
    endcase
  end

  assign irq_cmpa = glb_ie & flag_q[FB_CMPA] & mask_q[FB_CMPA];
  assign irq_ovf  = glb_ie & flag_q[FB_OVF]  & mask_q[FB_OVF];
  assign irq_cmpb = glb_ie & flag_q[FB_CMPB] & mask_q[FB_CMPB];
  assign match_a  = match[0];
  assign match_b  = match[1];
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       blk,
  input logic       cnt_we,
  input logic [7:0] cnt,
  input logic [2:0] csel,
  input logic       match_a,
  input logic       match_b,
  input logic       wrap,
  input logic [2:0] flags,
  input logic       gie,
  input logic       irq_a,
  input logic       irq_o,
  input logic       irq_b,
  input logic       ext_rise,
  input logic       ext_fall
);
  p_wr_sets_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> blk);
  p_blocked_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blk) |-> (!match_a && !match_b));
  p_match_flag_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |=> flags[0]);
  p_match_flag_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_b |=> flags[2]);
  p_match_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a || match_b) |-> tick);
  p_stop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (csel == 3'd0 && !cnt_we) |=> $stable(cnt));
  p_one_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_rise, ext_fall}));
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !cnt_we) |=> (cnt == 8'd0));
  p_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[1]);
  p_no_irq_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !(irq_a || irq_o || irq_b));
endmodule

bind tmr8_dual_cmp tmr8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .blk(blk), .cnt_we(cnt_we),
  .cnt(cnt_q), .csel(csel_q), .match_a(match_a), .match_b(match_b),
  .wrap(wrap), .flags(flag_q), .gie(glb_ie), .irq_a(irq_cmpa),
  .irq_o(irq_ovf), .irq_b(irq_cmpb), .ext_rise(ext_rise), .ext_fall(ext_fall)
);

// File: tb/tb_tmr8_dual_cmp.sv
module tb_tmr8_dual_cmp;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cnt_pin = 1'b0;
  logic       glb_ie = 1'b0;
  logic       irq_cmpa, irq_ovf, irq_cmpb, match_a, match_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  tmr8_dual_cmp dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model state
  logic [7:0] m_cnt, m_ca, m_cb;
  logic [2:0] m_cs, m_mask, m_flg;
  logic       m_blk, m_s1, m_s2, m_s3;
  int         m_pre;
  logic [7:0] last_rd;

  function automatic bit exp_tick(input logic [2:0] cs, input int pre,
                                  input bit r, input bit f);
    case (cs)
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return (pre % 8) == 7;
      3'd3: return (pre % 64) == 63;
      3'd4: return (pre % 256) == 255;
      3'd5: return (pre % 1024) == 1023;
      3'd6: return f;
      default: return r;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_ca;
      3'd2: return m_cb;
      3'd3: return {5'd0, m_cs};
      3'd4: return {5'd0, m_mask};
      3'd5: return {5'd0, m_flg};
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_ca = 0; m_cb = 0; m_cs = 0; m_mask = 0; m_flg = 0;
    m_blk = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0;
  endtask

  // one clock cycle: drive, check outputs vs model, advance model
  task automatic cyc(input bit we, input logic [2:0] a, input logic [7:0] d);
    bit t, ma, mb, ov;
    logic [2:0] clr;
    bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    t  = exp_tick(m_cs, m_pre, m_s2 & ~m_s3, ~m_s2 & m_s3);
    ma = t && !m_blk && (m_cnt == m_ca);
    mb = t && !m_blk && (m_cnt == m_cb);
    ov = t && (m_cnt == 8'hFF);
    last_rd = bus_rdata;
    chk($sformatf("R2 read addr %0d", a), bus_rdata, exp_read(a));
    chk("R9 irq vector {b,ovf,a}", {irq_cmpb, irq_ovf, irq_cmpa},
        {3{glb_ie}} & m_flg & m_mask);
    chk("R4 match strobes {b,a}", {match_b, match_a}, {mb, ma});
    clr = (we && a == 3'd5) ? d[2:0] : 3'd0;
    if (we && a == 3'd0) begin m_cnt = d; m_blk = 1; end
    else if (t) begin m_cnt = m_cnt + 8'd1; m_blk = 0; end
    if (we && a == 3'd1) m_ca = d;
    if (we && a == 3'd2) m_cb = d;
    if (we && a == 3'd3) m_cs = d[2:0];
    if (we && a == 3'd4) m_mask = d[2:0];
    m_flg = (m_flg & ~clr) | {mb, ov, ma};
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = cnt_pin;
    m_pre = m_pre + 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 3'd0, 8'd0);
  endtask

  task automatic rd(input logic [2:0] a);
    cyc(0, a, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] c0;
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a));
      chk($sformatf("R1 reset value addr %0d", a), last_rd, 8'd0);
    end
    chk("R1 irq and match low", {irq_cmpa, irq_ovf, irq_cmpb, match_a, match_b}, 5'd0);

    // R2 register write/readback
    cyc(1, 3'd1, 8'h5A); rd(3'd1); chk("R2 compare A readback", last_rd, 8'h5A);
    cyc(1, 3'd2, 8'hC3); rd(3'd2); chk("R2 compare B readback", last_rd, 8'hC3);
    cyc(1, 3'd4, 8'hFF); rd(3'd4); chk("R2 mask upper bits read zero", last_rd, 8'h07);
    rd(3'd7); chk("R2 unused address reads zero", last_rd, 8'h00);

    // R3 counter write blocks next-tick match
    cyc(1, 3'd4, 8'h00);
    cyc(1, 3'd1, 8'd20); cyc(1, 3'd2, 8'd200); cyc(1, 3'd5, 8'h07);
    cyc(1, 3'd0, 8'd20); cyc(1, 3'd3, 8'd1); cyc(1, 3'd3, 8'd0);
    rd(3'd5); chk("R3 blocked tick leaves flag A clear", last_rd, 8'h00);
    rd(3'd0); chk("R3 blocked tick still counts", last_rd, 8'd21);
    cyc(1, 3'd0, 8'd19); cyc(1, 3'd3, 8'd1); cyc(1, 3'd3, 8'd0);
    cyc(1, 3'd3, 8'd1); cyc(1, 3'd3, 8'd0);
    rd(3'd5); chk("R3 unblocked second tick sets flag A", last_rd, 8'h01);

    // R4 stopped counter at matching value sets nothing
    cyc(1, 3'd5, 8'h07); cyc(1, 3'd0, 8'd20); idle(12);
    rd(3'd5); chk("R4 no match without tick", last_rd, 8'h00);

    // R8 set and clear in the same cycle: set wins
    cyc(1, 3'd0, 8'd19); cyc(1, 3'd3, 8'd1); cyc(1, 3'd3, 8'd0);
    cyc(1, 3'd3, 8'd1); cyc(1, 3'd5, 8'h01); cyc(1, 3'd3, 8'd0);
    rd(3'd5); chk("R8 set beats clear", last_rd, 8'h01);
    cyc(1, 3'd5, 8'h01); rd(3'd5); chk("R8 write one clears", last_rd, 8'h00);
    cyc(1, 3'd5, 8'h00);

    // R9 interrupt gating
    cyc(1, 3'd0, 8'd19); cyc(1, 3'd3, 8'd1); cyc(1, 3'd3, 8'd0);
    cyc(1, 3'd3, 8'd1); cyc(1, 3'd3, 8'd0);
    cyc(1, 3'd4, 8'h01); glb_ie = 1'b1; rd(3'd5);
    chk("R9 irq_cmpa with flag, mask, enable", irq_cmpa, 1'b1);
    glb_ie = 1'b0; rd(3'd5);
    chk("R9 irq_cmpa off without global enable", irq_cmpa, 1'b0);

    // R7 wrap and overflow flag
    cyc(1, 3'd1, 8'd100); cyc(1, 3'd2, 8'd100); cyc(1, 3'd5, 8'h07);
    cyc(1, 3'd0, 8'hFF); cyc(1, 3'd3, 8'd1); cyc(1, 3'd3, 8'd0);
    rd(3'd0); chk("R7 wrap to zero", last_rd, 8'd0);
    rd(3'd5); chk("R7 overflow flag bit 1", last_rd, 8'h02);

    // R5 stop and divide-by-1024
    cyc(1, 3'd0, 8'd0); idle(40); rd(3'd0); chk("R5 stopped counter", last_rd, 8'd0);
    cyc(1, 3'd3, 8'd5); rd(3'd0); c0 = last_rd;
    idle(2047); rd(3'd0);
    chk("R5 /1024 gives two ticks in 2048 clocks", last_rd - c0, 8'd2);
    cyc(1, 3'd3, 8'd3); rd(3'd0); c0 = last_rd;
    idle(639); rd(3'd0);
    chk("R5 /64 gives ten ticks in 640 clocks", last_rd - c0, 8'd10);

    // R6 external pin edges
    cyc(1, 3'd3, 8'd7); cyc(1, 3'd0, 8'd0);
    for (int p = 0; p < 5; p++) begin
      cnt_pin = 1'b1; idle(4); cnt_pin = 1'b0; idle(4);
    end
    idle(4); rd(3'd0); chk("R6 rising edges count once each", last_rd, 8'd5);
    cyc(1, 3'd3, 8'd6); cyc(1, 3'd0, 8'd0);
    for (int p = 0; p < 5; p++) begin
      cnt_pin = 1'b1; idle(3); cnt_pin = 1'b0; idle(3);
    end
    idle(4); rd(3'd0); chk("R6 falling edges count once each", last_rd, 8'd5);

    // constrained random traffic, checked against the model every cycle
    for (int i = 0; i < 6000; i++) begin
      int sel;
      logic [2:0] a;
      logic [7:0] d;
      bit we;
      sel = $urandom_range(0, 15);
      we = sel < 6;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (we && a == 3'd3) d = (sel < 2) ? 8'($urandom_range(6, 7)) : 8'($urandom_range(1, 3));
      if (we && a == 3'd0 && sel > 2) we = 0;
      if ($urandom_range(0, 3) == 0) cnt_pin = ~cnt_pin;
      if ($urandom_range(0, 63) == 0) glb_ie = ~glb_ie;
      if ($urandom_range(0, 40) == 0) begin we = 1; a = 3'd5; d = 8'($urandom); end
      cyc(we, a, d);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule